// File: doc/BRIEF.md
# Remote-Frame Pending Flag Bank

This block keeps one sticky flag per message buffer of a CAN controller. A flag goes to 1 when the receive engine reports that a remote frame has landed in that buffer. Software uses the flag to see which buffers are waiting to answer a remote request. The flag drops again in three cases: the buffer later stores a data frame, the buffer finishes a transmission, or software writes a 0 to that bit.

The host side is a byte-wide bus. With the default sixteen buffers, the flags appear as two bytes. The low byte holds buffers 0 to 7 and the high byte holds buffers 8 to 15. A bus write can only clear flags: a 0 clears the bit and a 1 leaves it alone. A read that is part of a read-modify-write sequence returns all ones, so the write-back half of that sequence cannot clear anything by accident. Hardware setting always wins over any clear that lands in the same clock. An aggregate output tells an interrupt controller or a poll loop that at least one flag is up.

Top module: `remote_req_flags`

## Requirements
- R1: After synchronous reset, every flag is 0, `bus_rdata` is 0x00 and `any_pending` is 0.
- R2: A 1 on bit x of `rx_remote_done` makes flag x read 1 from the next clock on.
- R3: A write with `bus_wr`=1 clears each flag in the addressed byte whose `bus_wdata` bit is 0. Flags in the other byte keep their value. `bus_lane`=0 addresses flags 0–7 and `bus_lane`=1 addresses flags 8–15, with `bus_wdata` bit k mapping to flag 8·lane+k.
- R4: A 1 in `bus_wdata` leaves the matching flag unchanged, whether that flag is currently 0 or 1.
- R5: A 1 on bit x of `rx_data_done` clears flag x at the next clock.
- R6: A 1 on bit x of `tx_done` clears flag x at the next clock.
- R7: When a software write-0 and an `rx_remote_done` strobe hit the same flag in the same clock, the flag ends at 1.
- R8: When `rx_remote_done` and either `rx_data_done` or `tx_done` hit the same flag in the same clock, the flag ends at 1.
- R9: A read with `bus_rd`=1 and `bus_rmw`=1 returns 0xFF in `bus_rdata` one clock later, whatever the flag values are. The read does not change any flag.
- R10: A plain read (`bus_rd`=1, `bus_rmw`=0) loads the addressed byte of flags into `bus_rdata` at the next clock, with bit k equal to flag 8·lane+k. `bus_rdata` holds its value in clocks without a read.
- R11: `any_pending` is 1 exactly when at least one flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_remote_done | input | 16 | One-clock strobes, remote frame stored per buffer |
| rx_data_done | input | 16 | One-clock strobes, data frame stored per buffer |
| tx_done | input | 16 | One-clock strobes, transmission finished per buffer |
| bus_lane | input | 1 | Byte select: 0 = flags 0–7, 1 = flags 8–15 |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rmw | input | 1 | Marks the read as the read half of a read-modify-write |
| bus_wdata | input | 8 | Write data; a 0 clears the matching flag |
| bus_rdata | output | 8 | Registered read data |
| any_pending | output | 1 | High while any flag is set |

## Verification
A remote-frame set can fall in the same clock as a clear. That clear can come from a host write of 0 or from a data-frame or transmit-done strobe on the same buffer. The bench provokes both collisions from table rows that drive the colliding strobe and the write, or the strobes, together in one clock. It judges the result by reading both bytes back over the bus afterwards and expecting the contested bit at 1, while the neighbouring bits follow the clear.

// File: rtl/rrq_pkg.sv
package rrq_pkg;

    localparam int unsigned DEF_NUM_BUF = 16;
    localparam int unsigned DEF_BYTE_W  = 8;

    // Width of the byte-lane select for a given buffer count.
    function automatic int unsigned lane_bits(input int unsigned nbuf, input int unsigned bw);
        int unsigned n;
        n = nbuf / bw;
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/rrq_event_merge.sv
// Folds hardware strobes and host write data into one set and one clear vector.
module rrq_event_merge #(
    parameter int unsigned NUM_BUF = rrq_pkg::DEF_NUM_BUF,
    parameter int unsigned BYTE_W  = rrq_pkg::DEF_BYTE_W,
    localparam int unsigned LANES  = NUM_BUF / BYTE_W,
    localparam int unsigned LANE_W = rrq_pkg::lane_bits(NUM_BUF, BYTE_W)
) (
    input  logic [NUM_BUF-1:0] rx_remote_done,
    input  logic [NUM_BUF-1:0] rx_data_done,
    input  logic [NUM_BUF-1:0] tx_done,
    input  logic [LANE_W-1:0]  bus_lane,
    input  logic               bus_wr,
    input  logic [BYTE_W-1:0]  bus_wdata,
    output logic [NUM_BUF-1:0] set_vec,
    output logic [NUM_BUF-1:0] clr_vec
);

    logic [NUM_BUF-1:0] host_clr;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        // Only zero bits of the written byte request a clear.
        assign host_clr[l*BYTE_W +: BYTE_W] =
            (bus_wr && (bus_lane == LANE_W'(l))) ? ~bus_wdata : '0;
    end

    assign set_vec = rx_remote_done;
    assign clr_vec = host_clr | rx_data_done | tx_done;

endmodule

// File: rtl/rrq_flag_bank.sv
// One sticky flag per buffer; a set outranks every clear.
module rrq_flag_bank #(
    parameter int unsigned NUM_BUF = rrq_pkg::DEF_NUM_BUF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_BUF-1:0] set_vec,
    input  logic [NUM_BUF-1:0] clr_vec,
    output logic [NUM_BUF-1:0] flag_q
);

    for (genvar b = 0; b < NUM_BUF; b++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst) begin
                flag_q[b] <= 1'b0;
            end else if (set_vec[b]) begin
                flag_q[b] <= 1'b1;
            end else if (clr_vec[b]) begin
                flag_q[b] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/rrq_read_port.sv
// Registered byte read; read-modify-write reads return all ones.
module rrq_read_port #(
    parameter int unsigned NUM_BUF = rrq_pkg::DEF_NUM_BUF,
    parameter int unsigned BYTE_W  = rrq_pkg::DEF_BYTE_W,
    localparam int unsigned LANES  = NUM_BUF / BYTE_W,
    localparam int unsigned LANE_W = rrq_pkg::lane_bits(NUM_BUF, BYTE_W)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_BUF-1:0] flag_q,
    input  logic [LANE_W-1:0]  bus_lane,
    input  logic               bus_rd,
    input  logic               bus_rmw,
    output logic [BYTE_W-1:0]  bus_rdata
);

    logic [BYTE_W-1:0] lane_v [LANES];

    for (genvar l = 0; l < LANES; l++) begin : g_view
        assign lane_v[l] = flag_q[l*BYTE_W +: BYTE_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= bus_rmw ? '1 : lane_v[bus_lane];
        end
    end

endmodule

// File: rtl/remote_req_flags.sv
module remote_req_flags #(
    parameter int unsigned NUM_BUF = rrq_pkg::DEF_NUM_BUF,
    parameter int unsigned BYTE_W  = rrq_pkg::DEF_BYTE_W,
    localparam int unsigned LANE_W = rrq_pkg::lane_bits(NUM_BUF, BYTE_W)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_BUF-1:0] rx_remote_done,
    input  logic [NUM_BUF-1:0] rx_data_done,
    input  logic [NUM_BUF-1:0] tx_done,
    input  logic [LANE_W-1:0]  bus_lane,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic               bus_rmw,
    input  logic [BYTE_W-1:0]  bus_wdata,
    output logic [BYTE_W-1:0]  bus_rdata,
    output logic               any_pending
);

    logic [NUM_BUF-1:0] set_vec;
    logic [NUM_BUF-1:0] clr_vec;
    logic [NUM_BUF-1:0] flag_q;

    rrq_event_merge #(.NUM_BUF(NUM_BUF), .BYTE_W(BYTE_W)) u_merge (
        .rx_remote_done(rx_remote_done),
        .rx_data_done  (rx_data_done),
        .tx_done       (tx_done),
        .bus_lane      (bus_lane),
        .bus_wr        (bus_wr),
        .bus_wdata     (bus_wdata),
        .set_vec       (set_vec),
        .clr_vec       (clr_vec)
    );

    rrq_flag_bank #(.NUM_BUF(NUM_BUF)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .set_vec(set_vec),
        .clr_vec(clr_vec),
        .flag_q (flag_q)
    );

    rrq_read_port #(.NUM_BUF(NUM_BUF), .BYTE_W(BYTE_W)) u_read (
        .clk      (clk),
        .rst      (rst),
        .flag_q   (flag_q),
        .bus_lane (bus_lane),
        .bus_rd   (bus_rd),
        .bus_rmw  (bus_rmw),
        .bus_rdata(bus_rdata)
    );

    assign any_pending = |flag_q;

endmodule

// File: rtl/rrq_checker.sv
module rrq_checker #(
    parameter int unsigned NUM_BUF = 16,
    parameter int unsigned BYTE_W  = 8
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_BUF-1:0] rx_remote_done,
    input logic [NUM_BUF-1:0] rx_data_done,
    input logic [NUM_BUF-1:0] tx_done,
    input logic               bus_rd,
    input logic               bus_rmw,
    input logic [BYTE_W-1:0]  bus_rdata,
    input logic               any_pending,
    input logic [NUM_BUF-1:0] flag_q
);

    // R2, R7, R8: every strobed remote frame leaves its flag at 1.
    assert_remote_set_R2: assert property (@(posedge clk) disable iff (rst)
        (|rx_remote_done) |=> ((flag_q & $past(rx_remote_done)) == $past(rx_remote_done)));

    // R5, R6: hardware clears without a competing set leave the flag at 0.
    assert_hw_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (|((rx_data_done | tx_done) & ~rx_remote_done))
        |=> ((flag_q & $past((rx_data_done | tx_done) & ~rx_remote_done)) == '0));

    // R4: a flag can only rise because of a remote-frame strobe.
    assert_only_hw_sets_R4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(rx_remote_done)) == '0));

    // R9: read-modify-write reads return all ones.
    assert_rmw_ones_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_rmw) |=> (bus_rdata == '1));

    // R10: read data only moves on a read.
    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));

    // R11: pending can only rise after a remote frame arrives.
    assert_pending_rise_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(any_pending) |-> $past(|rx_remote_done));

endmodule

bind remote_req_flags rrq_checker #(.NUM_BUF(NUM_BUF), .BYTE_W(BYTE_W)) u_rrq_chk (
    .clk           (clk),
    .rst           (rst),
    .rx_remote_done(rx_remote_done),
    .rx_data_done  (rx_data_done),
    .tx_done       (tx_done),
    .bus_rd        (bus_rd),
    .bus_rmw       (bus_rmw),
    .bus_rdata     (bus_rdata),
    .any_pending   (any_pending),
    .flag_q        (flag_q)
);

// File: tb/test_remote_req_flags.sv
`timescale 1ns/1ps
module test_remote_req_flags;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] rx_remote_done = '0;
    logic [15:0] rx_data_done   = '0;
    logic [15:0] tx_done        = '0;
    logic        bus_lane  = 1'b0;
    logic        bus_wr    = 1'b0;
    logic        bus_rd    = 1'b0;
    logic        bus_rmw   = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        any_pending;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    remote_req_flags i_remote_req_flags (
        .clk(clk), .rst(rst),
        .rx_remote_done(rx_remote_done), .rx_data_done(rx_data_done), .tx_done(tx_done),
        .bus_lane(bus_lane), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rmw(bus_rmw),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .any_pending(any_pending)
    );

    typedef struct packed {
        logic        wr;
        logic        lane;
        logic [7:0]  wd;
        logic [15:0] set_v;
        logic [15:0] dclr;
        logic [15:0] tclr;
        logic [15:0] expect_v;
    } step_t;

    localparam int NSTEP = 11;
    localparam step_t STEPS [NSTEP] = '{
        '{1'b0, 1'b0, 8'h00, 16'h00FF, 16'h0000, 16'h0000, 16'h00FF}, // R2 low byte
        '{1'b0, 1'b0, 8'h00, 16'hFF00, 16'h0000, 16'h0000, 16'hFFFF}, // R2 high byte
        '{1'b1, 1'b0, 8'hF0, 16'h0000, 16'h0000, 16'h0000, 16'hFFF0}, // R3 low
        '{1'b1, 1'b1, 8'h0F, 16'h0000, 16'h0000, 16'h0000, 16'h0FF0}, // R3 high
        '{1'b0, 1'b0, 8'h00, 16'h0000, 16'h0030, 16'h0000, 16'h0FC0}, // R5
        '{1'b0, 1'b0, 8'h00, 16'h0000, 16'h0000, 16'h0300, 16'h0CC0}, // R6
        '{1'b1, 1'b0, 8'hFF, 16'h0000, 16'h0000, 16'h0000, 16'h0CC0}, // R4
        '{1'b1, 1'b0, 8'h00, 16'h0001, 16'h0000, 16'h0000, 16'h0C01}, // R7
        '{1'b0, 1'b0, 8'h00, 16'h2000, 16'h2000, 16'h2000, 16'h2C01}, // R8
        '{1'b1, 1'b1, 8'h00, 16'h0000, 16'h0000, 16'h0000, 16'h0001}, // R3 high all
        '{1'b0, 1'b0, 8'h00, 16'h0000, 16'h0001, 16'h0000, 16'h0000}  // R5 last flag
    };

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic do_read(input logic lane, input logic rmw, output logic [7:0] val);
        @(negedge clk);
        bus_lane = lane; bus_rd = 1'b1; bus_rmw = rmw;
        @(negedge clk);
        bus_rd = 1'b0; bus_rmw = 1'b0;
        val = bus_rdata;
    endtask

    task automatic read_both(output logic [15:0] val);
        logic [7:0] lo, hi;
        do_read(1'b0, 1'b0, lo);
        do_read(1'b1, 1'b0, hi);
        val = {hi, lo};
    endtask

    initial begin
        logic [15:0] got;
        logic [7:0]  b;
        repeat (3) @(negedge clk);
        // R1: outputs during and after reset
        check8("R1 rdata", bus_rdata, 8'h00);
        check8("R1 pending", {7'd0, any_pending}, 8'h00);
        rst = 1'b0;
        read_both(got);
        check8("R1 flags lo", got[7:0], 8'h00);
        check8("R1 flags hi", got[15:8], 8'h00);

        // R9: rmw read with all flags clear
        do_read(1'b0, 1'b1, b);
        check8("R9 rmw empty", b, 8'hFF);

        for (int i = 0; i < NSTEP; i++) begin
            @(negedge clk);
            bus_wr = STEPS[i].wr; bus_lane = STEPS[i].lane; bus_wdata = STEPS[i].wd;
            rx_remote_done = STEPS[i].set_v; rx_data_done = STEPS[i].dclr; tx_done = STEPS[i].tclr;
            @(negedge clk);
            bus_wr = 1'b0; bus_wdata = '0;
            rx_remote_done = '0; rx_data_done = '0; tx_done = '0;
            check8($sformatf("R11 pending step %0d", i), {7'd0, any_pending},
                   {7'd0, |STEPS[i].expect_v});
            read_both(got);
            check8($sformatf("R10 step %0d lo", i), got[7:0],  STEPS[i].expect_v[7:0]);
            check8($sformatf("R10 step %0d hi", i), got[15:8], STEPS[i].expect_v[15:8]);
        end

        // R4: writing ones to clear flags does not set them
        @(negedge clk);
        bus_wr = 1'b1; bus_lane = 1'b1; bus_wdata = 8'hFF;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
        read_both(got);
        check8("R4 ones stay clear hi", got[15:8], 8'h00);
        check8("R4 pending", {7'd0, any_pending}, 8'h00);

        // R9: rmw read with flags partly set, and flags unchanged afterwards
        @(negedge clk);
        rx_remote_done = 16'h8002;
        @(negedge clk);
        rx_remote_done = '0;
        do_read(1'b1, 1'b1, b);
        check8("R9 rmw hi", b, 8'hFF);
        read_both(got);
        check8("R9 flags kept lo", got[7:0], 8'h02);
        check8("R9 flags kept hi", got[15:8], 8'h80);

        // R10: rdata holds without a read
        repeat (3) @(negedge clk);
        check8("R10 hold", bus_rdata, 8'h80);

        // R1: reset again clears set flags
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check8("R1 rdata after reset", bus_rdata, 8'h00);
        check8("R1 pending after reset", {7'd0, any_pending}, 8'h00);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule